// File: doc/BRIEF.md
# Serial NOR Flash Line Fetch Engine

This block sits between an instruction cache and a serial NOR flash device. When the cache misses, it presents a line address. The engine opens one flash transaction and returns one full cache line of 32 bytes, one byte per response beat, in ascending address order. Each transaction carries one read command, one 24-bit address, an optional run of dummy clocks and the data burst. A base register moves bus address zero to any 4 KiB boundary of the flash.

A three-bit mode input chooses the read opcode and sets how many data lines carry each phase. The command, address and data phases can each use one, two or four lines. An identification mode sends the JEDEC ID command instead and returns the ID stream. A select bit decides which pin supplies single-line receive data. The serial clock runs at the engine clock divided by (n+1). An enable bit gates the start of new transactions.

Top module: `spi_flash_fetch`

## Requirements
- R1: The read opcode is sent MSB first and depends on the mode, with the number of command lines in brackets: 0 gives 0x03 (1), 1 gives 0x0B (1), 2 gives 0x3B (1), 3 gives 0x6B (1), 4 gives 0xBB (1), 5 gives 0xEB (1), 6 gives 0xBB (2) and 7 gives 0xEB (4).
- R2: In modes 0 and 1, address and data both use 1 line. Mode 2 uses 1 address line and 2 data lines. Mode 3 uses 1 and 4. Modes 4 and 6 use 2 and 2. Modes 5 and 7 use 4 and 4. On one line, io_out[0] carries the bits. On two lines, io_out[1]/io_in[1] carry the higher bit of each pair. On four lines, bit 3 carries the highest bit. Each beat moves the most significant bits that remain.
- R3: The 24-bit flash address is (base << 12) + (line << 5), taken modulo 2^24.
- R4: The dummy count (0..15) sets the number of SCK periods between the address and the data. io_oe is 0 from the first dummy clock until the transaction ends. While a phase is being sent, io_oe sets exactly the lines that phase uses.
- R5: One SCK period lasts max(div,1)+1 engine cycles. SCK is low whenever cs_n is high.
- R6: With the ID bit set, the engine sends 0x9F on one line with no address and no dummy phase. It then returns 32 bytes received on one line, whatever the mode and dummy inputs hold.
- R7: For single-line data, rx_sel=0 receives from io_in[0] and rx_sel=1 receives from io_in[1].
- R8: With enable low, req_ready stays 0 and cs_n stays high. Clearing enable during a transaction lets that transaction finish.
- R9: Each request returns exactly 32 bytes in ascending address order. Each byte comes as a one-cycle rsp_valid, which is only raised while a transaction is open. rsp_last marks the 32nd byte and no other.
- R10: Between transactions, cs_n stays high for at least one SCK period.
- R11: The engine changes outputs only on the SCK falling edge and samples inputs on the rising edge, so io_out never changes while SCK is high and cs_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Allows new transactions |
| cfg_id_read | input | 1 | Selects identification readout |
| cfg_rx_sel | input | 1 | Single-line receive pin select |
| cfg_mode | input | 3 | Read mode, opcode and line widths |
| cfg_dummy | input | 4 | Dummy SCK periods |
| cfg_div | input | DIV_W | Clock divider n |
| cfg_base | input | BASE_W | Flash base in 4 KiB units |
| req_valid | input | 1 | Line request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_line | input | ADDR_W-5 | Line index |
| rsp_valid | output | 1 | Response byte present |
| rsp_data | output | 8 | Response byte |
| rsp_last | output | 1 | Final byte of the line |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Active-low chip select |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line input values |

## Verification
Two cases share a single cycle. In the first, the falling SCK edge that ends one beat is also the edge where the phase changes, the shift register advances and the data lines are released. A behavioural flash in the bench checks the lane enables and captured bits on every rising edge across all eight modes and several dummy counts and dividers. In the second, clearing enable coincides with an open refill: the bench clears enable in the cycle right after acceptance, then requires all 32 bytes and afterwards no further chip select while a request is held.

// File: rtl/spi_flash_fetch.sv
module spi_flash_fetch #(
  parameter int LINE_BYTES = 32,
  parameter int ADDR_W     = 24,
  parameter int DIV_W      = 8,
  parameter int BASE_W     = 16,
  parameter int BASE_SHIFT = 12
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_enable,
  input  logic                                  cfg_id_read,
  input  logic                                  cfg_rx_sel,
  input  logic [2:0]                            cfg_mode,
  input  logic [3:0]                            cfg_dummy,
  input  logic [DIV_W-1:0]                      cfg_div,
  input  logic [BASE_W-1:0]                     cfg_base,
  input  logic                                  req_valid,
  output logic                                  req_ready,
  input  logic [ADDR_W-$clog2(LINE_BYTES)-1:0]  req_line,
  output logic                                  rsp_valid,
  output logic [7:0]                            rsp_data,
  output logic                                  rsp_last,
  output logic                                  sck,
  output logic                                  cs_n,
  output logic [3:0]                            io_out,
  output logic [3:0]                            io_oe,
  input  logic [3:0]                            io_in
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int DBITS  = LINE_BYTES * 8;
  localparam int BEAT_W = $clog2(DBITS) + 1;
  localparam int SR_W   = 8 + ADDR_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(LINE_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_CMD, S_ADDR, S_DUMMY, S_DATA, S_GAP} state_t;

  state_t             st, nxt_st;
  logic [DIV_W-1:0]   cnt, lim, lim_d, nc, half;
  logic [DIV_W:0]     lim_p1;
  logic [SR_W-1:0]    sr;
  logic [BEAT_W-1:0]  beats, nxt_beats;
  logic [1:0]         cw, aw, dw, pw, cw_d, aw_d, dw_d;
  logic [3:0]         dmy, lane_mask, rxn, rxn_nx;
  logic               idm, rxs, cs_q, sck_q, sck_en, rise, fall, accept;
  logic [7:0]         op_d, rxb, rx_nx, rd_q;
  logic               rv_q, rl_q;
  logic [OFF_W-1:0]   nbyte;
  logic [ADDR_W-1:0]  fa;

  always_comb begin
    op_d = 8'h03; cw_d = 2'd0; aw_d = 2'd0; dw_d = 2'd0;
    if (cfg_id_read) op_d = 8'h9F;
    else case (cfg_mode)
      3'd0: op_d = 8'h03;
      3'd1: op_d = 8'h0B;
      3'd2: begin op_d = 8'h3B; dw_d = 2'd1; end
      3'd3: begin op_d = 8'h6B; dw_d = 2'd2; end
      3'd4: begin op_d = 8'hBB; aw_d = 2'd1; dw_d = 2'd1; end
      3'd5: begin op_d = 8'hEB; aw_d = 2'd2; dw_d = 2'd2; end
      3'd6: begin op_d = 8'hBB; cw_d = 2'd1; aw_d = 2'd1; dw_d = 2'd1; end
      default: begin op_d = 8'hEB; cw_d = 2'd2; aw_d = 2'd2; dw_d = 2'd2; end
    endcase
  end

  assign fa = ADDR_W'({cfg_base, {BASE_SHIFT{1'b0}}}) + ADDR_W'({req_line, {OFF_W{1'b0}}});
  assign lim_d = (cfg_div == '0) ? DIV_W'(1) : cfg_div;
  assign lim_p1 = {1'b0, lim} + 1'b1;
  assign half = lim_p1[DIV_W:1];
  assign nc = (cnt == lim) ? '0 : cnt + 1'b1;
  assign sck_en = (st == S_CMD) || (st == S_ADDR) || (st == S_DUMMY) || (st == S_DATA);
  assign rise = sck_en && (nc == half);
  assign fall = sck_en && (cnt == lim);
  assign req_ready = (st == S_IDLE) && cfg_enable;
  assign accept = req_valid && req_ready;
  assign pw = (st == S_CMD) ? cw : (st == S_ADDR) ? aw : dw;
  assign lane_mask = (pw == 2'd0) ? 4'b0001 : (pw == 2'd1) ? 4'b0011 : 4'b1111;
  assign io_oe = (st == S_CMD || st == S_ADDR) ? lane_mask : 4'b0000;

  always_comb begin
    case (pw)
      2'd0:    io_out = {3'b000, sr[SR_W-1]} & io_oe;
      2'd1:    io_out = {2'b00, sr[SR_W-1 -: 2]} & io_oe;
      default: io_out = sr[SR_W-1 -: 4] & io_oe;
    endcase
  end

  always_comb begin
    case (dw)
      2'd0:    rx_nx = {rxb[6:0], rxs ? io_in[1] : io_in[0]};
      2'd1:    rx_nx = {rxb[5:0], io_in[1:0]};
      default: rx_nx = {rxb[3:0], io_in};
    endcase
    rxn_nx = rxn + (4'd1 << dw);
  end

  always_comb begin
    nxt_st = st;
    nxt_beats = '0;
    case (st)
      S_CMD: if (idm) begin
               nxt_st = S_DATA; nxt_beats = BEAT_W'(DBITS >> dw);
             end else begin
               nxt_st = S_ADDR; nxt_beats = BEAT_W'(ADDR_W >> aw);
             end
      S_ADDR: if (dmy != 4'd0) begin
                nxt_st = S_DUMMY; nxt_beats = BEAT_W'(dmy);
              end else begin
                nxt_st = S_DATA; nxt_beats = BEAT_W'(DBITS >> dw);
              end
      S_DUMMY: begin nxt_st = S_DATA; nxt_beats = BEAT_W'(DBITS >> dw); end
      S_DATA:  nxt_st = S_GAP;
      default: nxt_st = st;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; lim <= DIV_W'(1); sr <= '0; beats <= '0;
      cw <= '0; aw <= '0; dw <= '0; dmy <= '0; idm <= 1'b0; rxs <= 1'b0;
      cs_q <= 1'b1; sck_q <= 1'b0; rxb <= '0; rxn <= '0; nbyte <= '0;
      rv_q <= 1'b0; rl_q <= 1'b0; rd_q <= '0;
    end else begin
      rv_q <= 1'b0;
      rl_q <= 1'b0;
      if (st == S_IDLE) begin
        if (accept) begin
          st <= S_CMD; cnt <= '0; lim <= lim_d; sr <= {op_d, fa};
          beats <= BEAT_W'(8 >> cw_d);
          cw <= cw_d; aw <= aw_d; dw <= dw_d;
          dmy <= cfg_id_read ? 4'd0 : cfg_dummy;
          idm <= cfg_id_read; rxs <= cfg_rx_sel;
          cs_q <= 1'b0; rxn <= '0; nbyte <= '0;
        end
      end else if (st == S_GAP) begin
        cnt <= nc;
        if (cnt == lim) st <= S_IDLE;
      end else begin
        cnt <= nc;
        sck_q <= (nc >= half);
        if (rise && st == S_DATA) begin
          rxb <= rx_nx;
          if (rxn_nx == 4'd8) begin
            rxn <= '0; rv_q <= 1'b1; rd_q <= rx_nx;
            rl_q <= (nbyte == LAST); nbyte <= nbyte + 1'b1;
          end else begin
            rxn <= rxn_nx;
          end
        end
        if (fall) begin
          case (pw)
            2'd0:    sr <= sr << 1;
            2'd1:    sr <= sr << 2;
            default: sr <= sr << 4;
          endcase
          if (beats == BEAT_W'(1)) begin
            st <= nxt_st; beats <= nxt_beats;
            if (nxt_st == S_GAP) cs_q <= 1'b1;
          end else begin
            beats <= beats - 1'b1;
          end
        end
      end
    end
  end

  assign sck = sck_q;
  assign cs_n = cs_q;
  assign rsp_valid = rv_q;
  assign rsp_data = rd_q;
  assign rsp_last = rl_q;

  // R5
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n) cs_n |-> !sck);
  // R4
  rx_lines_free_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> io_oe == 4'b0000);
  // R8
  start_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(cs_n) |-> $past(cfg_enable));
  // R9
  rsp_in_txn_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> $past(!cs_n));
  // R9
  last_is_beat_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_last |-> rsp_valid);
  // R11
  drive_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && io_out != $past(io_out)) |-> $fell(sck));
endmodule

// File: tb/spi_flash_fetch_bench.sv
module spi_flash_fetch_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cfg_enable, cfg_id_read, cfg_rx_sel;
  logic [2:0] cfg_mode;
  logic [3:0] cfg_dummy;
  logic [7:0] cfg_div;
  logic [15:0] cfg_base;
  logic req_valid, req_ready;
  logic [18:0] req_line;
  logic rsp_valid, rsp_last, sck, cs_n;
  logic [7:0] rsp_data;
  logic [3:0] io_out, io_oe, io_in;

  spi_flash_fetch u_spi_flash_fetch (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_id_read(cfg_id_read),
    .cfg_rx_sel(cfg_rx_sel), .cfg_mode(cfg_mode), .cfg_dummy(cfg_dummy), .cfg_div(cfg_div),
    .cfg_base(cfg_base), .req_valid(req_valid), .req_ready(req_ready), .req_line(req_line),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  int vectors = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  int m_C, m_A, m_D, m_cw, m_aw, m_dw, m_per, prev_per;
  bit m_sel, m_id;
  logic [7:0] m_op;
  logic [23:0] m_fa;
  int rises, oe_err, per_err, gap_err, r11_err;
  logic [31:0] cmd_got, adr_got;
  longint last_rise, cs_rise_t;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] arr_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[20:16], a[23:21]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] exp_byte(input int b);
    if (m_id) return 8'(8'hC8 ^ (b * 37));
    return arr_byte(m_fa + 24'(b));
  endfunction

  function automatic logic [3:0] lanes(input logic [3:0] v, input int lw);
    if (lw == 0) return {3'b000, v[0]};
    if (lw == 1) return {2'b00, v[1:0]};
    return v;
  endfunction

  function automatic logic [3:0] lmask(input int lw);
    return (lw == 0) ? 4'b0001 : (lw == 1) ? 4'b0011 : 4'b1111;
  endfunction

  always @(posedge cs_n) begin
    cs_rise_t = $time;
    prev_per = m_per;
  end

  always @(negedge cs_n) begin
    rises = 0; cmd_got = 0; adr_got = 0;
    if (cs_rise_t != 0 && ($time - cs_rise_t) < longint'(prev_per * 4)) gap_err++;
  end

  always @(io_out) if (cs_n === 1'b0 && sck === 1'b1) r11_err++;

  always @(posedge sck) if (cs_n === 1'b0) begin
    if (rises > 0 && ($time - last_rise) != longint'(m_per * 4)) per_err++;
    last_rise = $time;
    if (rises < m_C) begin
      if (io_oe !== lmask(m_cw)) oe_err++;
      cmd_got = (cmd_got << (1 << m_cw)) | 32'(lanes(io_out, m_cw));
    end else if (rises < m_C + m_A) begin
      if (io_oe !== lmask(m_aw)) oe_err++;
      adr_got = (adr_got << (1 << m_aw)) | 32'(lanes(io_out, m_aw));
    end else if (io_oe !== 4'b0000) oe_err++;
    rises++;
  end

  always @(negedge sck) if (cs_n === 1'b0 && rises >= m_C + m_A + m_D) begin
    int j, w, bpb;
    logic [7:0] b;
    logic [3:0] v;
    j = rises - (m_C + m_A + m_D);
    w = 1 << m_dw;
    bpb = 8 / w;
    if (j < 256 / w) begin
      b = exp_byte(j / bpb);
      v = 4'((b >> (8 - ((j % bpb) + 1) * w)) & ((1 << w) - 1));
      case (m_dw)
        0: io_in = m_sel ? {2'b10, v[0], ~v[0]} : {2'b10, ~v[0], v[0]};
        1: io_in = {~v[1:0], v[1:0]};
        default: io_in = v;
      endcase
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 190000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  task automatic cfg_set(input int mode, input int dmy, input int div, input bit id,
                         input bit sel, input logic [15:0] base, input logic [18:0] line);
    logic [27:0] t;
    @(negedge clk);
    cfg_mode = 3'(mode); cfg_dummy = 4'(dmy); cfg_div = 8'(div);
    cfg_id_read = id; cfg_rx_sel = sel; cfg_base = base; cfg_enable = 1'b1;
    req_line = line;
    m_cw = 0; m_aw = 0; m_dw = 0;
    case (mode)
      0: m_op = 8'h03;
      1: m_op = 8'h0B;
      2: begin m_op = 8'h3B; m_dw = 1; end
      3: begin m_op = 8'h6B; m_dw = 2; end
      4: begin m_op = 8'hBB; m_aw = 1; m_dw = 1; end
      5: begin m_op = 8'hEB; m_aw = 2; m_dw = 2; end
      6: begin m_op = 8'hBB; m_cw = 1; m_aw = 1; m_dw = 1; end
      default: begin m_op = 8'hEB; m_cw = 2; m_aw = 2; m_dw = 2; end
    endcase
    if (id) begin
      m_op = 8'h9F; m_cw = 0; m_aw = 0; m_dw = 0;
    end
    m_C = 8 >> m_cw;
    m_A = id ? 0 : (24 >> m_aw);
    m_D = id ? 0 : dmy;
    m_per = ((div == 0) ? 1 : div) + 1;
    m_sel = sel; m_id = id;
    t = {base, 12'h000} + 28'({line, 5'b00000});
    m_fa = t[23:0];
    oe_err = 0; per_err = 0;
  endtask

  task automatic xfer(input string tag, input bit drop_en);
    int got, k;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (drop_en) cfg_enable = 1'b0;
    got = 0; k = 0;
    while (got < 32 && k < 30000) begin
      if (rsp_valid) begin
        chk(rsp_data == exp_byte(got), $sformatf("%s byte %0d", tag, got), rsp_data, exp_byte(got));
        chk(rsp_last == (got == 31), $sformatf("R9 last flag byte %0d", got), rsp_last, got == 31);
        got++;
      end
      @(negedge clk);
      k++;
    end
    chk(got == 32, "R9 byte count", got, 32);
    while (!cs_n) @(negedge clk);
    chk(cmd_got[7:0] == m_op, "R1 opcode", cmd_got[7:0], m_op);
    if (!m_id) chk(adr_got[23:0] == m_fa, "R3 address", adr_got[23:0], m_fa);
    chk(oe_err == 0, "R4 line enables", oe_err, 0);
    chk(per_err == 0, "R5 sck period", per_err, 0);
  endtask

  initial begin
    int bad;
    int divs[4];
    divs[0] = 0; divs[1] = 1; divs[2] = 2; divs[3] = 5;
    cfg_enable = 0; cfg_id_read = 0; cfg_rx_sel = 0; cfg_mode = 0; cfg_dummy = 0;
    cfg_div = 1; cfg_base = 0; req_valid = 0; req_line = 0; io_in = 0;
    m_C = 8; m_A = 24; m_D = 0; m_cw = 0; m_aw = 0; m_dw = 0; m_per = 2; prev_per = 0;
    m_sel = 0; m_id = 0; m_op = 0; m_fa = 0; rises = 0; oe_err = 0; per_err = 0;
    gap_err = 0; r11_err = 0; cmd_got = 0; adr_got = 0; last_rise = 0; cs_rise_t = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R8 reset cs_n", cs_n, 1);
    chk(sck == 1'b0, "R5 reset sck", sck, 0);
    chk(io_oe == 4'b0000, "R4 reset io_oe", io_oe, 0);
    chk(rsp_valid == 1'b0, "R9 reset rsp_valid", rsp_valid, 0);
    chk(req_ready == 1'b0, "R8 reset req_ready", req_ready, 0);

    // R8: requests held while disabled
    bad = 0;
    req_valid = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (req_ready || !cs_n) bad++;
    end
    req_valid = 1'b0;
    chk(bad == 0, "R8 disabled", bad, 0);

    // R1 R2 R4: all modes, several dummy counts and dividers
    for (int m = 0; m < 8; m++) begin
      for (int d = 0; d < 3; d++) begin
        cfg_set(m, (d == 0) ? 0 : ((d == 1) ? 3 : 15), divs[(m + d) % 4], 1'b0, 1'b0,
                16'(m * 17 + d), 19'(m * 1000 + d * 77 + 5));
        xfer((m >= 2) ? "R2 data" : "R1 data", 1'b0);
      end
    end

    // R6: ID readout ignores mode and dummy
    cfg_set(5, 9, 1, 1'b1, 1'b0, 16'h0123, 19'h00042);
    xfer("R6 id", 1'b0);
    cfg_set(0, 0, 2, 1'b1, 1'b1, 16'h0000, 19'h00000);
    xfer("R6 id rx1", 1'b0);

    // R7: single-line receive from io_in[1]
    cfg_set(0, 0, 1, 1'b0, 1'b1, 16'h0042, 19'h01234);
    xfer("R7 rx1", 1'b0);
    cfg_set(1, 8, 3, 1'b0, 1'b1, 16'h0100, 19'h00007);
    xfer("R7 rx1 fast", 1'b0);

    // R3: address wraps at 2^24
    cfg_set(0, 0, 1, 1'b0, 1'b0, 16'hFFFF, 19'h7FFFF);
    xfer("R3 wrap", 1'b0);
    cfg_set(3, 4, 0, 1'b0, 1'b0, 16'h0FFF, 19'h00080);
    xfer("R3 quad", 1'b0);

    // R8: enable dropped during a transaction
    cfg_set(4, 2, 1, 1'b0, 1'b0, 16'h0020, 19'h00300);
    xfer("R8 drop", 1'b1);
    bad = 0;
    req_valid = 1'b1;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (req_ready || !cs_n) bad++;
    end
    req_valid = 1'b0;
    chk(bad == 0, "R8 no restart", bad, 0);

    chk(gap_err == 0, "R10 cs gap", gap_err, 0);
    chk(r11_err == 0, "R11 drive edge", r11_err, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule